// File: doc/BRIEF.md
# Bit-Serial Associative Array with Multiwrite

This block is a word-organized content-addressable array. Every word holds two operand fields (A and B) and a small set of tag bits. Beside each word sits one match flag, and the flags together form the detector plane. One command seeds the detector plane, searches one bit column of every word against a per-field criterion, and then writes a pattern into every matching word in parallel. The write can also go to the next lower neighbour (word index plus one) of each matching word. The column being searched in the A and B fields is chosen by a bit-position counter per field, and a command can either advance that counter by one or sweep it up to a limit register, so a single command can cover a whole field bit by bit.

Arithmetic and pattern work is built by a sequencer outside the block. The sequencer chains commands that move groups of words from one stored state to the next. It reads back which words responded from the detector-plane output and from the "some word matches" flag. Two sequences come up often: sequential loading, where a single match is walked down the array by lower-neighbour writes, and masked multi-bit searches whose results accumulate in the match flags.

Top module: `aap_array`

## Requirements
- R1: After reset every match flag is 0, `busy` and `any_match` are 0, both field counters and both limit registers are 0, and every stored bit is 0.
- R2: For an associative command (bit 37 = 0), bits 36:35 prepare the detector plane at acceptance: 01 clears every flag, 10 sets every flag, 00 and 11 leave the flags as they are.
- R3: A word's flag survives a step only if every searched bit agrees. The 3-bit search codes are 0 none, 1 zero, 2 one, 3 equal to the data-register bit, and 4 its complement. A and B compare against `dreg` at their own counter, and tag t compares against `dreg[t]`. Flags never become set during a normal-mode step, so searches across steps are ANDed.
- R4: The 2-bit write codes are 0 none, 1 write 0, 2 write 1, and 3 write the data-register bit. They apply at the current counter position of A and B, and to tag t. Only the target words of a step are written.
- R5: Counter code 1 (single) advances the field counter by one after the command's final step. Code 0 (and 3) holds it.
- R6: Counter code 2 (sweep) takes one step per clock. The field advances after each step until it equals its limit, and the command ends after the step in which every sweeping field is at its limit. `busy` is high for exactly the number of steps.
- R7: When bit 0 is 1, each step writes the lower neighbour of every matching word. After the last step the flags move down one word. A match in the bottom word writes nothing and is dropped.
- R8: A non-associative command (bit 37 = 1) takes effect at acceptance and takes no steps. Op bits 36:34 select the action: 0 loads the A counter, 1 the A limit, 2 the B counter, 3 the B limit, using bits 2:0; 4 sets the flag of word 0 alone.
- R9: `any_match` is 1 exactly when at least one match flag is set.
- R10: A command is taken when `cmd_valid` is high and `busy` is low. Command bits: A field at 34:28 and B field at 27:21, each as search(3), write(2), counter(2). Tag t is at bits 20-5t down to 16-5t, as search(3), write(2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd | input | 38 | Command word |
| dreg | input | 6 | Data register, read live during steps |
| busy | output | 1 | Associative command in progress |
| any_match | output | 1 | OR of all match flags |
| match_vec | output | 16 | Detector plane, bit i is word i |

## Verification
A corrupted stored bit stays hidden until a search reaches its column. At that point it shows up as a wrong bit in `match_vec` right after the command's last step. A counter that is off by one moves the searched column, and the next full-field search then misses the expected word. A flag that is set wrongly, or a lower-neighbour shift that goes wrong, shows up on `match_vec` and `any_match` one clock after the step that caused it. During a sequential load this is checked on every walk of the single match.

// File: rtl/aap_pkg.sv
package aap_pkg;
  parameter int A_W   = 6;
  parameter int B_W   = 6;
  parameter int N_TAG = 4;

  localparam int D_W   = (A_W > B_W) ? A_W : B_W;
  localparam int P_W   = $clog2(D_W);
  localparam int CMD_W = 1 + 2 + 7 + 7 + 5 * N_TAG + 1;

  typedef enum logic [1:0] {
    DP_KEEP  = 2'd0,
    DP_CLR   = 2'd1,
    DP_SET   = 2'd2,
    DP_KEEP2 = 2'd3
  } dp_e;

  typedef struct packed {
    logic [2:0] srch;
    logic [1:0] wr;
    logic [1:0] cnt;
  } fld_t;

  typedef struct packed {
    logic [2:0] srch;
    logic [1:0] wr;
  } tagc_t;

  typedef struct packed {
    logic               kind;
    dp_e                dp;
    fld_t               a;
    fld_t               b;
    tagc_t [0:N_TAG-1]  tg;
    logic               lower;
  } cmd_t;

  // {care, want} for one searched bit
  function automatic logic [1:0] srch_crit(input logic [2:0] code, input logic d);
    case (code)
      3'd1:    return 2'b10;
      3'd2:    return 2'b11;
      3'd3:    return {1'b1, d};
      3'd4:    return {1'b1, ~d};
      default: return 2'b00;
    endcase
  endfunction

  // {enable, value} for one written bit
  function automatic logic [1:0] wr_crit(input logic [1:0] code, input logic d);
    case (code)
      2'd1:    return 2'b10;
      2'd2:    return 2'b11;
      2'd3:    return {1'b1, d};
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [P_W-1:0] bump(input logic [P_W-1:0] p, input int fw);
    return (p == P_W'(fw - 1)) ? '0 : p + 1'b1;
  endfunction
endpackage

// File: rtl/aap_ptr.sv
module aap_ptr
  import aap_pkg::*;
#(
  parameter int FW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_ctr,
  input  logic           ld_lim,
  input  logic [P_W-1:0] ld_val,
  input  logic           adv,
  output logic [P_W-1:0] ctr,
  output logic [P_W-1:0] lim
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctr <= '0;
      lim <= '0;
    end else begin
      if (ld_ctr)   ctr <= ld_val;
      else if (adv) ctr <= bump(ctr, FW);
      if (ld_lim)   lim <= ld_val;
    end
  end
endmodule

// File: rtl/aap_word.sv
module aap_word
  import aap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [P_W-1:0]   a_pos,
  input  logic [P_W-1:0]   b_pos,
  input  logic [1:0]       a_sc,
  input  logic [1:0]       b_sc,
  input  logic [N_TAG-1:0] t_care,
  input  logic [N_TAG-1:0] t_want,
  input  logic             wr_en,
  input  logic [1:0]       a_wc,
  input  logic [1:0]       b_wc,
  input  logic [N_TAG-1:0] t_we,
  input  logic [N_TAG-1:0] t_wv,
  output logic             agree
);
  logic [A_W-1:0]   a_q;
  logic [B_W-1:0]   b_q;
  logic [N_TAG-1:0] t_q;
  logic             a_ok, b_ok, t_ok;

  always_comb begin
    a_ok  = !a_sc[1] || (a_q[a_pos] == a_sc[0]);
    b_ok  = !b_sc[1] || (b_q[b_pos] == b_sc[0]);
    t_ok  = &(~t_care | ~(t_q ^ t_want));
    agree = a_ok && b_ok && t_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      t_q <= '0;
    end else if (wr_en) begin
      if (a_wc[1]) a_q[a_pos] <= a_wc[0];
      if (b_wc[1]) b_q[b_pos] <= b_wc[0];
      for (int t = 0; t < N_TAG; t++)
        if (t_we[t]) t_q[t] <= t_wv[t];
    end
  end
endmodule

// File: rtl/aap_array.sv
module aap_array
  import aap_pkg::*;
#(
  parameter int NW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd,
  input  logic [D_W-1:0]   dreg,
  output logic             busy,
  output logic             any_match,
  output logic [NW-1:0]    match_vec
);
  cmd_t          ci, cq;
  logic          busy_q;
  logic [NW-1:0] flags, agree, hit, wr_en;
  logic [2:0]    na_op;
  logic [P_W-1:0] na_val;

  // named events for the checker
  logic accept, acc_assoc, seed_acc, step, step_last, lower_q;
  dp_e  cmd_dp;

  assign ci        = cmd_t'(cmd);
  assign na_op     = cmd[CMD_W-2 -: 3];
  assign na_val    = cmd[P_W-1:0];
  assign accept    = cmd_valid && !busy_q;
  assign acc_assoc = accept && !ci.kind;
  assign seed_acc  = accept && ci.kind && (na_op == 3'd4);
  assign cmd_dp    = ci.dp;
  assign step      = busy_q;
  assign lower_q   = cq.lower;

  // field counters: index 0 is A, 1 is B
  logic [P_W-1:0] ctr [2];
  logic [P_W-1:0] lim [2];
  logic [1:0]     sweep, single, pend, adv;

  assign sweep  = {cq.b.cnt == 2'd2, cq.a.cnt == 2'd2};
  assign single = {cq.b.cnt == 2'd1, cq.a.cnt == 2'd1};

  always_comb begin
    for (int g = 0; g < 2; g++) pend[g] = sweep[g] && (ctr[g] != lim[g]);
  end
  assign step_last = step && !(|pend);

  generate
    for (genvar g = 0; g < 2; g++) begin : g_ptr
      localparam int FW = (g == 0) ? A_W : B_W;
      assign adv[g] = step && (pend[g] || (single[g] && step_last));
      aap_ptr #(.FW(FW)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_ctr (accept && ci.kind && (na_op == 3'(2 * g))),
        .ld_lim (accept && ci.kind && (na_op == 3'(2 * g + 1))),
        .ld_val (na_val),
        .adv    (adv[g]),
        .ctr    (ctr[g]),
        .lim    (lim[g])
      );
    end
  endgenerate

  // criteria for this step
  logic [1:0]       a_sc, b_sc, a_wc, b_wc;
  logic [N_TAG-1:0] t_care, t_want, t_we, t_wv;

  always_comb begin
    a_sc = srch_crit(cq.a.srch, dreg[ctr[0]]);
    b_sc = srch_crit(cq.b.srch, dreg[ctr[1]]);
    a_wc = wr_crit(cq.a.wr, dreg[ctr[0]]);
    b_wc = wr_crit(cq.b.wr, dreg[ctr[1]]);
    for (int t = 0; t < N_TAG; t++) begin
      {t_care[t], t_want[t]} = srch_crit(cq.tg[t].srch, dreg[t]);
      {t_we[t],   t_wv[t]}   = wr_crit(cq.tg[t].wr, dreg[t]);
    end
  end

  assign hit   = flags & agree;
  assign wr_en = !step ? '0 : (cq.lower ? {hit[NW-2:0], 1'b0} : hit);

  generate
    for (genvar i = 0; i < NW; i++) begin : g_word
      aap_word u_word (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_pos  (ctr[0]),
        .b_pos  (ctr[1]),
        .a_sc   (a_sc),
        .b_sc   (b_sc),
        .t_care (t_care),
        .t_want (t_want),
        .wr_en  (wr_en[i]),
        .a_wc   (a_wc),
        .b_wc   (b_wc),
        .t_we   (t_we),
        .t_wv   (t_wv),
        .agree  (agree[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      flags  <= '0;
      cq     <= '0;
    end else if (accept) begin
      cq <= ci;
      if (!ci.kind) begin
        busy_q <= 1'b1;
        if (ci.dp == DP_CLR)      flags <= '0;
        else if (ci.dp == DP_SET) flags <= '1;
      end else if (na_op == 3'd4) begin
        flags <= NW'(1);
      end
    end else if (step) begin
      flags <= (step_last && cq.lower) ? {hit[NW-2:0], 1'b0} : hit;
      if (step_last) busy_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign match_vec = flags;
  assign any_match = |flags;
endmodule

// File: rtl/aap_array_chk.sv
module aap_array_chk
  import aap_pkg::*;
#(
  parameter int NW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_assoc,
  input dp_e           cmd_dp,
  input logic          seed_acc,
  input logic          step,
  input logic          step_last,
  input logic          lower_q,
  input logic          busy,
  input logic [NW-1:0] match_vec
);
  // R2
  dp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_assoc && (cmd_dp == DP_CLR) |=> (match_vec == '0));

  // R2
  dp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_assoc && (cmd_dp == DP_SET) |=> (&match_vec));

  // R3
  and_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !lower_q |=> ((match_vec & ~$past(match_vec)) == '0));

  // R7
  bottom_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_last && lower_q |=> !match_vec[0]);

  // R7
  shift_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_last && lower_q |=> ($countones(match_vec) <= $countones($past(match_vec))));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !step_last |=> busy);

  // R8
  seed_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_acc |=> (match_vec == NW'(1)));
endmodule

bind aap_array aap_array_chk #(.NW(NW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_assoc (acc_assoc),
  .cmd_dp    (cmd_dp),
  .seed_acc  (seed_acc),
  .step      (step),
  .step_last (step_last),
  .lower_q   (lower_q),
  .busy      (busy),
  .match_vec (match_vec)
);

// File: tb/aap_array_tb.sv
module aap_array_tb;
  import aap_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [CMD_W-1:0] cmd = '0;
  logic [D_W-1:0]   dreg = '0;
  logic             busy, any_match;
  logic [NW-1:0]    match_vec;

  int n_run = 0, n_fail = 0, last_steps = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aap_array #(.NW(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .dreg(dreg), .busy(busy), .any_match(any_match), .match_vec(match_vec)
  );

  // ---- command builders (encodings from R2, R8, R10) ----
  function automatic logic [6:0] fld(input int s, input int w, input int c);
    return {3'(s), 2'(w), 2'(c)};
  endfunction
  function automatic logic [5*N_TAG-1:0] tgf(input int t, input int s, input int w);
    logic [5*N_TAG-1:0] r = '0;
    r[5*N_TAG-1-5*t -: 5] = {3'(s), 2'(w)};
    return r;
  endfunction
  function automatic logic [CMD_W-1:0] acmd(input int dp, input logic [6:0] af,
      input logic [6:0] bf, input logic [5*N_TAG-1:0] tf, input bit low);
    return {1'b0, 2'(dp), af, bf, tf, low};
  endfunction
  function automatic logic [CMD_W-1:0] ncmd(input int op, input int v);
    logic [CMD_W-1:0] r = '0;
    r[CMD_W-1] = 1'b1;
    r[CMD_W-2 -: 3] = 3'(op);
    r[2:0] = 3'(v);
    return r;
  endfunction

  // ---- independent expectations ----
  function automatic logic [5:0] val(input int w);
    return 6'((3 * w + 1) % 64);
  endfunction
  function automatic logic [NW-1:0] colmask(input int b, input bit v);
    logic [NW-1:0] m;
    for (int w = 0; w < NW; w++) begin
      logic [5:0] x = val(w);
      m[w] = (x[b] == v);
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [CMD_W-1:0] c);
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd = c; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    last_steps = 0;
    while (busy) begin
      last_steps++;
      @(negedge clk);
    end
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 any_match", any_match, 0);
    check("R1 match_vec", match_vec, 0);
    issue(acmd(2, fld(0,0,0), fld(2,0,0), '0, 0));   // B bit0 ones
    check("R1 B storage zero", match_vec, 0);
    issue(acmd(2, fld(2,0,0), fld(0,0,0), tgf(3,2,0), 0));
    check("R1 A/tag storage zero", match_vec, 0);
  endtask

  task automatic t_dp();
    issue(acmd(2, '0, '0, '0, 0));
    check("R2 set all", match_vec, 16'hFFFF);
    check("R9 any set", any_match, 1);
    issue(acmd(0, '0, '0, '0, 0));
    check("R2 keep", match_vec, 16'hFFFF);
    issue(acmd(1, '0, '0, '0, 0));
    check("R2 clear", match_vec, 0);
    check("R9 any clear", any_match, 0);
  endtask

  task automatic t_load();
    issue(ncmd(1, 5));
    issue(ncmd(0, 0));
    issue(ncmd(4, 0));
    check("R8 seed word0", match_vec, 16'h0001);
    dreg = val(0);
    issue(acmd(0, fld(0,3,2), '0, '0, 0));
    check("R6 sweep steps", last_steps, 6);
    for (int w = 1; w < NW; w++) begin
      issue(ncmd(0, 0));
      dreg = val(w);
      issue(acmd(0, fld(0,3,2), '0, '0, 1));
      check("R7 walk", match_vec, 32'(1) << w);
    end
    issue(ncmd(0, 0));
    dreg = 6'h3F;
    issue(acmd(0, fld(0,3,2), '0, '0, 1));
    check("R7 bottom dropped", match_vec, 0);
    check("R9 no match", any_match, 0);
    for (int k = 0; k < NW; k++) begin
      issue(ncmd(0, 0));
      dreg = val(k);
      issue(acmd(2, fld(3,0,2), '0, '0, 0));
      check("R3 equal-D field search", match_vec, 32'(1) << k);
    end
  endtask

  task automatic t_crit();
    issue(ncmd(0, 0));
    dreg = ~val(5);
    issue(acmd(2, fld(4,0,2), '0, '0, 0));
    check("R3 complement search", match_vec, 16'h0020);
    issue(ncmd(0, 2));
    issue(acmd(2, fld(1,0,0), '0, '0, 0));
    check("R3 zeros bit2", match_vec, colmask(2, 0));
    issue(acmd(2, fld(2,0,0), '0, '0, 0));
    check("R3 ones bit2", match_vec, colmask(2, 1));
    check("R5 hold counter", last_steps, 1);
    issue(ncmd(0, 0));
    issue(acmd(2, fld(2,0,1), '0, '0, 0));   // ones at bit0, single advance
    check("R5 single one step", last_steps, 1);
    issue(acmd(0, fld(2,0,0), '0, '0, 0));   // keep, ones at bit1
    check("R3 AND accumulate", match_vec, colmask(0, 1) & colmask(1, 1));
    issue(acmd(2, fld(2,0,0), '0, '0, 0));
    check("R5 counter moved to bit1", match_vec, colmask(1, 1));
  endtask

  task automatic t_write();
    issue(ncmd(0, 0));
    issue(acmd(2, fld(2,0,0), '0, tgf(1,0,2), 0));   // tag1 <= 1 where bit0 = 1
    issue(acmd(2, '0, '0, tgf(1,2,0), 0));
    check("R4 tag write one", match_vec, colmask(0, 1));
    dreg = 6'h00;
    issue(acmd(2, '0, '0, tgf(1,0,3), 0));
    issue(acmd(2, '0, '0, tgf(1,2,0), 0));
    check("R4 tag write D=0", match_vec, 0);
    issue(acmd(2, '0, '0, tgf(2,0,2), 0));
    dreg = 6'h04;
    issue(acmd(2, '0, '0, tgf(2,3,0), 0));
    check("R3 tag search D=1", match_vec, 16'hFFFF);
    dreg = 6'h00;
    issue(acmd(2, '0, '0, tgf(2,3,0), 0));
    check("R3 tag search D=0", match_vec, 0);
    issue(ncmd(2, 3));
    issue(acmd(2, fld(2,0,0), fld(0,2,0), '0, 0));   // B bit3 <= 1 where A bit0 = 1
    issue(acmd(2, '0, fld(2,0,0), '0, 0));
    check("R4 B write one", match_vec, colmask(0, 1));
    issue(acmd(2, '0, fld(1,0,0), '0, 0));
    check("R4 B untouched words", match_vec, colmask(0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dp();
    t_load();
    t_crit();
    t_write();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule